// File: doc/BRIEF.md
# Stall-Aware Five-Stage Instruction Pipeline

This block models how instruction tokens move through an in-order pipeline of five stages: fetch, decode, operand read, execute and store. Each token carries an identifier and an execute latency. One token can enter per cycle, and one can retire per cycle, as long as no instruction spends extra time in execute. There is no real decode, no data path and no hazard logic between instructions. The block tracks only where each token is, when it stalls, and where the empty slots appear.

A token may need several cycles in the execute stage. While it stays there, the three stages in front of it keep their contents and the input stops accepting tokens. The store stage receives empty slots during this time, so the retirement stream shows a gap. A valid bit for each stage is exported so that an observer can follow this behaviour cycle by cycle.

Top module: `stall_pipe`

## Requirements
- R1: A token with latency code 0, accepted at clock edge k, appears on the retirement port (ret_valid=1, ret_id equal to its id) after edge k+4, for exactly one cycle.
- R2: Tokens with latency code 0, accepted on consecutive edges, retire on consecutive cycles in the order they were accepted. in_ready stays high throughout.
- R3: in_lat holds the execute latency minus one (code 0 to 7 means 1 to 8 cycles). A token accepted at edge k with code c retires after edge k+4+c, provided it is not delayed by an earlier token.
- R4: While the execute stage holds a token that still has remaining cycles, the fetch, decode and operand stages keep their tokens. Their valid bits stay unchanged.
- R5: in_ready is low exactly while the execute stage holds a token with remaining cycles. A token offered while in_ready is low is not taken. It is accepted later, only once, on the first edge where in_ready is high.
- R6: For every stall cycle, an empty slot enters the store stage. A token with code c therefore leaves a retirement gap of c cycles after the token ahead of it.
- R7: Empty slots, including those caused by in_valid being low, never produce ret_valid. A gap in the input shows up as an equal gap in retirement.
- R8: A synchronous active-high reset clears every stage valid bit. After reset, occ is 0, ret_valid is 0 and in_ready is 1, and no token accepted before the reset ever retires.
- R9: Bit i of occ is the valid bit of stage i, where 0 is fetch, 1 is decode, 2 is operand read, 3 is execute and 4 is store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A token is offered this cycle |
| in_id | input | 8 | Identifier of the offered token |
| in_lat | input | 3 | Execute latency minus one |
| in_ready | output | 1 | Fetch can take a token on the next edge |
| ret_valid | output | 1 | A token retires from the store stage this cycle |
| ret_id | output | 8 | Identifier of the retiring token |
| occ | output | 5 | Valid bit of each stage, bit 0 is fetch |

## Verification
The assertions assume that a token offered while in_ready is low has not been consumed. They also assume that the inputs change only away from the active edge. The bench meets both assumptions by driving inputs on the falling edge and by holding an offered token until it sees in_ready high before a rising edge. The properties also assume that reset lasts at least one edge. The bench always holds reset for two edges, including the case where reset arrives while tokens are in flight.

// File: rtl/pipe_pkg.sv
package pipe_pkg;
    localparam int ID_W       = 8;
    localparam int LAT_W      = 3;
    localparam int NUM_STAGES = 5;
    localparam int EXEC_IDX   = 3;
    localparam int STORE_IDX  = NUM_STAGES - 1;

    typedef struct packed {
        logic             valid;
        logic [ID_W-1:0]  id;
        logic [LAT_W-1:0] lat;
    } token_t;

    localparam token_t EMPTY_TOKEN = '0;

    function automatic logic has_cycles_left(token_t t, logic [LAT_W-1:0] left);
        return t.valid && (left != '0);
    endfunction
endpackage

// File: rtl/pipe_slot.sv
module pipe_slot
    import pipe_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   adv,
    input  token_t d,
    output token_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= EMPTY_TOKEN;
        end else if (adv) begin
            q <= d;
        end
    end
endmodule

// File: rtl/exec_slot.sv
module exec_slot
    import pipe_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  token_t d,
    output token_t q,
    output logic   busy
);
    logic [LAT_W-1:0] left;

    assign busy = has_cycles_left(q, left);

    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= EMPTY_TOKEN;
            left <= '0;
        end else if (busy) begin
            left <= left - 1'b1;
        end else begin
            q    <= d;
            left <= d.valid ? d.lat : '0;
        end
    end
endmodule

// File: rtl/stall_pipe.sv
module stall_pipe
    import pipe_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [ID_W-1:0]  in_id,
    input  logic [LAT_W-1:0] in_lat,
    output logic             in_ready,
    output logic             ret_valid,
    output logic [ID_W-1:0]  ret_id,
    output logic [NUM_STAGES-1:0] occ
);
    token_t stg [NUM_STAGES];
    token_t in_tok;
    token_t store_d;
    logic   stall;

    assign in_tok.valid = in_valid;
    assign in_tok.id    = in_id;
    assign in_tok.lat   = in_lat;

    genvar gi;
    generate
        for (gi = 0; gi < EXEC_IDX; gi++) begin : g_front
            if (gi == 0) begin : g_fetch
                pipe_slot u_slot (.clk(clk), .rst(rst), .adv(!stall),
                                  .d(in_tok), .q(stg[gi]));
            end else begin : g_mid
                pipe_slot u_slot (.clk(clk), .rst(rst), .adv(!stall),
                                  .d(stg[gi-1]), .q(stg[gi]));
            end
        end
        for (gi = 0; gi < NUM_STAGES; gi++) begin : g_occ
            assign occ[gi] = stg[gi].valid;
        end
    endgenerate

    exec_slot u_exec (
        .clk  (clk),
        .rst  (rst),
        .d    (stg[EXEC_IDX-1]),
        .q    (stg[EXEC_IDX]),
        .busy (stall)
    );

    assign store_d = stall ? EMPTY_TOKEN : stg[EXEC_IDX];

    pipe_slot u_store (.clk(clk), .rst(rst), .adv(1'b1),
                       .d(store_d), .q(stg[STORE_IDX]));

    assign in_ready  = !stall;
    assign ret_valid = stg[STORE_IDX].valid;
    assign ret_id    = stg[STORE_IDX].id;
endmodule

// File: rtl/stall_pipe_chk.sv
module stall_pipe_chk
    import pipe_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  in_ready,
    input logic                  ret_valid,
    input logic [NUM_STAGES-1:0] occ
);
    // R4: front stages frozen across a stall edge
    p_front_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> occ[EXEC_IDX-1:0] == $past(occ[EXEC_IDX-1:0]));

    // R6: a stall edge sends an empty slot to store
    p_bubble_r6: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> !ret_valid);

    // R5: not ready only when execute is occupied
    p_ready_r5: assert property (@(posedge clk) disable iff (rst)
        !in_ready |-> occ[EXEC_IDX]);

    // R7: retirement only for a token that was in execute
    p_retire_src_r7: assert property (@(posedge clk) disable iff (rst)
        ret_valid |-> $past(occ[EXEC_IDX]));

    // R2: free-flowing operand stage feeds execute
    p_advance_r2: assert property (@(posedge clk) disable iff (rst)
        (in_ready && occ[EXEC_IDX-1]) |=> occ[EXEC_IDX]);

    // R8: reset empties everything
    p_reset_r8: assert property (@(posedge clk)
        rst |=> (occ == '0) && in_ready && !ret_valid);
endmodule

bind stall_pipe stall_pipe_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .ret_valid (ret_valid),
    .occ       (occ)
);

// File: tb/test_stall_pipe.sv
module test_stall_pipe;
    import pipe_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [ID_W-1:0]  in_id = '0;
    logic [LAT_W-1:0] in_lat = '0;
    logic in_ready, ret_valid;
    logic [ID_W-1:0] ret_id;
    logic [NUM_STAGES-1:0] occ;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    int rel = 0;
    int nret = 0;
    int nrdy = 0;
    int rid  [16];
    int rrel [16];
    logic [NUM_STAGES-1:0] occ_log [32];

    always #5 clk = ~clk;

    stall_pipe i_stall_pipe (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_id(in_id),
        .in_lat(in_lat), .in_ready(in_ready), .ret_valid(ret_valid),
        .ret_id(ret_id), .occ(occ)
    );

    always @(posedge clk) rel <= rst ? 0 : rel + 1;

    always @(negedge clk) begin
        if (rel > 0) begin
            if (rel < 32) occ_log[rel] = occ;
            if (!in_ready) nrdy++;
            if (ret_valid && nret < 16) begin
                rid[nret]  = int'(ret_id);
                rrel[nret] = rel;
                nret++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        nret = 0;
        nrdy = 0;
        for (int i = 0; i < 32; i++) occ_log[i] = '0;
        rst = 1'b0;
    endtask

    task automatic push(input int id, input int code);
        in_valid = 1'b1;
        in_id    = ID_W'(id);
        in_lat   = LAT_W'(code);
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_ret(input int idx, input int id, input int r, input string req);
        chk(rid[idx] == id, req, rid[idx], id);
        chk(rrel[idx] == r, req, rrel[idx], r);
    endtask

    task automatic t_reset();
        do_reset();
        chk(occ == '0, "R8", int'(occ), 0);
        chk(ret_valid == 1'b0, "R8", int'(ret_valid), 0);
        chk(in_ready == 1'b1, "R8", int'(in_ready), 1);
        push(8'h71, 3);
        push(8'h72, 0);
        do_reset();
        chk(occ == '0, "R8", int'(occ), 0);
        idle(14);
        chk(nret == 0, "R8", nret, 0);
    endtask

    task automatic t_single();
        do_reset();
        push(8'h11, 0);
        idle(8);
        chk(nret == 1, "R1", nret, 1);
        expect_ret(0, 8'h11, 5, "R1");
        chk(occ_log[1] == 5'b00001, "R9", int'(occ_log[1]), 1);
        chk(occ_log[3] == 5'b00100, "R9", int'(occ_log[3]), 4);
    endtask

    task automatic t_stream();
        do_reset();
        for (int i = 0; i < 6; i++) push(8'h20 + i, 0);
        idle(8);
        chk(nret == 6, "R2", nret, 6);
        for (int i = 0; i < 6; i++) expect_ret(i, 8'h20 + i, i + 5, "R2");
        chk(nrdy == 0, "R2", nrdy, 0);
    endtask

    task automatic t_gaps();
        do_reset();
        push(8'h31, 0);
        idle(1);
        push(8'h32, 0);
        idle(8);
        chk(nret == 2, "R7", nret, 2);
        expect_ret(0, 8'h31, 5, "R7");
        expect_ret(1, 8'h32, 7, "R7");
    endtask

    task automatic t_stall();
        do_reset();
        push(8'h40, 0);
        push(8'h41, 3);
        push(8'h42, 0);
        push(8'h43, 0);
        push(8'h44, 0);
        push(8'h45, 0);
        idle(10);
        chk(nret == 6, "R5", nret, 6);
        expect_ret(0, 8'h40, 5, "R6");
        expect_ret(1, 8'h41, 9, "R3");
        expect_ret(2, 8'h42, 10, "R4");
        expect_ret(3, 8'h43, 11, "R4");
        expect_ret(4, 8'h44, 12, "R4");
        expect_ret(5, 8'h45, 13, "R5");
        chk(nrdy == 3, "R5", nrdy, 3);
        chk(occ_log[6] == 5'b01111, "R4", int'(occ_log[6]), 15);
        chk(occ_log[8] == 5'b01111, "R9", int'(occ_log[8]), 15);
    endtask

    task automatic t_max();
        do_reset();
        push(8'h51, 7);
        idle(14);
        chk(nret == 1, "R3", nret, 1);
        expect_ret(0, 8'h51, 12, "R3");
        chk(nrdy == 7, "R5", nrdy, 7);
    endtask

    task automatic t_pair();
        do_reset();
        push(8'h61, 1);
        push(8'h62, 1);
        idle(10);
        chk(nret == 2, "R3", nret, 2);
        expect_ret(0, 8'h61, 6, "R3");
        expect_ret(1, 8'h62, 8, "R6");
    endtask

    initial begin
        t_reset();
        t_single();
        t_stream();
        t_gaps();
        t_stall();
        t_max();
        t_pair();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule